// File: doc/BRIEF.md
# Cascadeable 3x3 Pixel Convolver

This block runs a 3x3 convolution window across an image that arrives one column per clock. Three signed 12-bit pixels, one for each of the rows A, B and C, arrive together on every clock. Each row keeps its three most recent pixels in a short shift register, so the window moves one column to the right on every clock. The nine pixels in the window are multiplied by nine stored signed fractional coefficients. The products are summed, and a 16-bit cascade input is added. The cascade input lets an earlier convolver stage contribute to this one. The result leaves on a 16-bit cascade output every clock, rounded to 12 integer and 4 fraction bits.

The coefficients are written three at a time, one for each row. A 2-bit set-select code chooses which window position the three values are written to. The code zero leaves every stored coefficient as it is. Line buffers for image rows and border handling belong to the blocks around this one.

Top module: `pixel_conv3x3`

## Requirements
- R1: On every clock edge without reset, each row shifts its window by one position. The pixel on that row's input becomes the newest entry and the oldest entry is dropped. Position 3 (newest) uses coefficient set 3, position 2 uses set 2, and position 1 (oldest) uses set 1.
- R2: Let t be a clock edge. The value of casOut after edge t is the sum, over the nine window entries held after edge t-4, of pixel × coefficient. To that sum is added the casIn value sampled at edge t-3, and the result is then rounded as in R7. The coefficients used are the ones held after edge t-4.
- R3: A value on casIn reaches casOut through four register stages. If every coefficient is zero, casOut after edge t+3 equals the casIn value sampled at edge t, exactly.
- R4: If a pixel p enters on one row at edge n and all other pixels are zero, casOut follows p×set3/16ths... more precisely: casOut shows p times that row's set-3 coefficient after edge n+4, p times the set-2 coefficient after edge n+5, and p times the set-1 coefficient after edge n+6. Each value is rounded as in R7.
- R5: Code coefSel = 1, 2 or 3 writes coefA, coefB and coefC into the coefficients of set 1, 2 or 3 for rows A, B and C respectively. The write takes effect at that clock edge.
- R6: Code coefSel = 0 leaves every stored coefficient unchanged, whatever values are on coefA, coefB and coefC.
- R7: The full sum is taken with 9 fraction bits, with casIn scaled up by 2^5. Rounding adds 2^-5 and keeps 4 fraction bits, discarding the rest toward minus infinity.
- R8: casOut keeps only the 16 least significant bits of the rounded result. A result outside the range -2048 to 2047.9375 wraps around modulo 2^16.
- R9: A synchronous reset (rst high at an edge) clears the window, the coefficients and every pipeline stage. casOut reads zero after each reset edge.
- R10: Pixels are signed 12-bit integers in two's complement. A coefficient code c is a signed 10-bit value meaning c/512, so the range is -1.0 to 511/512. casIn and casOut are signed 16-bit values in units of 1/16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pixA | input | 12 | Pixel for row A, signed integer |
| pixB | input | 12 | Pixel for row B, signed integer |
| pixC | input | 12 | Pixel for row C, signed integer |
| coefA | input | 10 | Coefficient to write for row A, signed, in units of 1/512 |
| coefB | input | 10 | Coefficient to write for row B, signed, in units of 1/512 |
| coefC | input | 10 | Coefficient to write for row C, signed, in units of 1/512 |
| coefSel | input | 2 | Set-select code: 0 holds every coefficient, 1 to 3 write that set |
| casIn | input | 16 | Cascade input, signed, in units of 1/16 |
| casOut | output | 16 | Rounded cascade output, signed, in units of 1/16 |

## Verification
An impulse on a single row exposes the order of the window taps and the pipeline depth. If set 1 and set 3 were swapped, or one stage were added or missing, the coefficients would show up in the wrong order or in the wrong cycle. Cascade-only runs with every coefficient zero catch a cascade path whose length differs from the product path. A missing scale factor also shows there, because casOut then differs from the value that went into casIn. Coefficients of ±16 and ±17 hit the rounding boundary, where a truncating design or one that rounds toward zero reads one step off. Full-scale negative pixels multiplied by the -1.0 coefficient force a wrap, and a design that saturates would give a different value there. Long random runs mix loads, holds and cascade values, and they catch a write to the wrong set or a hold code that still writes.

// File: rtl/conv3_pkg.sv
package conv3_pkg;
  localparam int PKG_PIX_W    = 12;
  localparam int PKG_COEF_W   = 10;
  localparam int PKG_CAS_W    = 16;
  localparam int PKG_CAS_FRAC = 4;
  localparam int PKG_ROWS     = 3;
  localparam int PKG_TAPS     = 3;
  localparam int PKG_SEL_W    = $clog2(PKG_TAPS + 1);

  // strobes from control to datapath
  typedef struct packed {
    logic                clear;
    logic [PKG_TAPS-1:0] coefLoad;
  } ctrl_t;
endpackage

// File: rtl/conv3_ctrl.sv
module conv3_ctrl
  import conv3_pkg::*;
#(
  parameter int TAPS  = PKG_TAPS,
  parameter int SEL_W = PKG_SEL_W
) (
  input  logic             rst,
  input  logic [SEL_W-1:0] coefSel,
  output ctrl_t            ctrl
);
  // set code k (1..TAPS) writes the coefficients of window position k
  always_comb begin
    ctrl.clear = rst;
    for (int t = 0; t < TAPS; t++) begin
      ctrl.coefLoad[t] = (coefSel == SEL_W'(t + 1));
    end
  end
endmodule

// File: rtl/conv3_datapath.sv
module conv3_datapath
  import conv3_pkg::*;
#(
  parameter int PIX_W    = PKG_PIX_W,
  parameter int COEF_W   = PKG_COEF_W,
  parameter int CAS_W    = PKG_CAS_W,
  parameter int CAS_FRAC = PKG_CAS_FRAC,
  parameter int ROWS     = PKG_ROWS,
  parameter int TAPS     = PKG_TAPS
) (
  input  logic                           clk,
  input  ctrl_t                          ctrl,
  input  logic [ROWS-1:0][PIX_W-1:0]     pixCol,
  input  logic [ROWS-1:0][COEF_W-1:0]    coefCol,
  input  logic [CAS_W-1:0]               casIn,
  output logic [CAS_W-1:0]               casOut
);
  localparam int FRAC   = COEF_W - 1;
  localparam int SHIFT  = FRAC - CAS_FRAC;
  localparam int PROD_W = PIX_W + COEF_W;
  localparam int ROW_W  = PROD_W + $clog2(TAPS) + 1;
  localparam int SUM_W  = ROW_W + $clog2(ROWS) + 2;

  logic [ROWS-1:0][ROW_W-1:0] rowAccAll;
  logic [ROWS-1:0][ROW_W-1:0] rowSumAll;

  // one window, coefficient bank and product row per image row
  for (genvar r = 0; r < ROWS; r++) begin : gRow
    logic signed [PIX_W-1:0]  win  [TAPS];   // index 0 = oldest pixel
    logic signed [COEF_W-1:0] kReg [TAPS];   // index t = set t+1
    logic signed [PROD_W-1:0] prod [TAPS];
    logic signed [ROW_W-1:0]  rowAcc;

    always_ff @(posedge clk) begin
      if (ctrl.clear) begin
        for (int t = 0; t < TAPS; t++) begin
          win[t]  <= '0;
          kReg[t] <= '0;
          prod[t] <= '0;
        end
      end else begin
        win[TAPS-1] <= pixCol[r];
        for (int t = 0; t < TAPS - 1; t++) win[t] <= win[t+1];
        for (int t = 0; t < TAPS; t++) begin
          if (ctrl.coefLoad[t]) kReg[t] <= coefCol[r];
          prod[t] <= PROD_W'(win[t]) * PROD_W'(kReg[t]);
        end
      end
    end

    always_comb begin
      rowAcc = '0;
      for (int t = 0; t < TAPS; t++) rowAcc = rowAcc + ROW_W'(prod[t]);
    end
    assign rowAccAll[r] = rowAcc;
  end

  // cascade path: casD1, casD2, total, casOut = four stages
  logic signed [CAS_W-1:0] casD1, casD2;
  logic signed [SUM_W-1:0] total, totalNext, rounded;

  always_comb begin
    totalNext = SUM_W'(casD2) <<< SHIFT;
    for (int r = 0; r < ROWS; r++) begin
      totalNext = totalNext + SUM_W'($signed(rowSumAll[r]));
    end
    rounded = total + SUM_W'(1 << (SHIFT - 1));
  end

  always_ff @(posedge clk) begin
    if (ctrl.clear) begin
      casD1     <= '0;
      casD2     <= '0;
      rowSumAll <= '0;
      total     <= '0;
      casOut    <= '0;
    end else begin
      casD1     <= casIn;
      casD2     <= casD1;
      rowSumAll <= rowAccAll;
      total     <= totalNext;
      casOut    <= CAS_W'(rounded >>> SHIFT);
    end
  end

  // assertion helper: edges seen since the last reset, saturating at 3
  logic [1:0] sinceRst;
  always_ff @(posedge clk) begin
    if (ctrl.clear) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  // R1: oldest tap of row A holds the pixel that entered three edges ago
  assert_window_oldest_R1: assert property (@(posedge clk) disable iff (ctrl.clear)
    (sinceRst == 2'd3) |-> (gRow[0].win[0] == $signed($past(pixCol[0], 3))));
endmodule

// File: rtl/pixel_conv3x3.sv
module pixel_conv3x3
  import conv3_pkg::*;
#(
  parameter int PIX_W    = PKG_PIX_W,
  parameter int COEF_W   = PKG_COEF_W,
  parameter int CAS_W    = PKG_CAS_W,
  parameter int CAS_FRAC = PKG_CAS_FRAC,
  parameter int SEL_W    = PKG_SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PIX_W-1:0]  pixA,
  input  logic [PIX_W-1:0]  pixB,
  input  logic [PIX_W-1:0]  pixC,
  input  logic [COEF_W-1:0] coefA,
  input  logic [COEF_W-1:0] coefB,
  input  logic [COEF_W-1:0] coefC,
  input  logic [SEL_W-1:0]  coefSel,
  input  logic [CAS_W-1:0]  casIn,
  output logic [CAS_W-1:0]  casOut
);
  ctrl_t ctrl;

  conv3_ctrl #(.TAPS(PKG_TAPS), .SEL_W(SEL_W)) u_ctrl (
    .rst(rst), .coefSel(coefSel), .ctrl(ctrl)
  );

  conv3_datapath #(
    .PIX_W(PIX_W), .COEF_W(COEF_W), .CAS_W(CAS_W), .CAS_FRAC(CAS_FRAC),
    .ROWS(PKG_ROWS), .TAPS(PKG_TAPS)
  ) u_dp (
    .clk(clk), .ctrl(ctrl),
    .pixCol({pixC, pixB, pixA}),
    .coefCol({coefC, coefB, coefA}),
    .casIn(casIn), .casOut(casOut)
  );

  // R5: code 1 writes row A's set-1 coefficient from the port
  assert_coef_load_R5: assert property (@(posedge clk) disable iff (rst)
    (coefSel == SEL_W'(1)) |=> (u_dp.gRow[0].kReg[0] == $signed($past(coefA))));

  // R6: code 0 leaves row A's coefficients unchanged
  assert_coef_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (coefSel == '0) |=> ($stable(u_dp.gRow[0].kReg[0]) && $stable(u_dp.gRow[0].kReg[1])
                         && $stable(u_dp.gRow[0].kReg[2])));

  // R9: output reads zero after a reset edge
  assert_reset_clears_R9: assert property (@(posedge clk)
    rst |=> (casOut == '0));

  // R9: reset also clears the stored coefficients
  assert_reset_coef_R9: assert property (@(posedge clk)
    rst |=> (u_dp.gRow[1].kReg[1] == '0));
endmodule

// File: tb/pixel_conv3x3_test.sv
`timescale 1ns/1ps
module pixel_conv3x3_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [11:0] pixA, pixB, pixC;
  logic [9:0]  coefA, coefB, coefC;
  logic [1:0]  coefSel;
  logic [15:0] casIn;
  logic [15:0] casOut;

  int    total = 0;
  int    fails = 0;
  bit    checkOn = 1'b0;
  bit    done = 1'b0;
  string curReq = "R9";

  always #2 clk = ~clk;

  pixel_conv3x3 uut (
    .clk(clk), .rst(rst), .pixA(pixA), .pixB(pixB), .pixC(pixC),
    .coefA(coefA), .coefB(coefB), .coefC(coefC), .coefSel(coefSel),
    .casIn(casIn), .casOut(casOut)
  );

  // behavioural reference: window[row][pos], pos 0 = oldest, coef[row][set-1]
  int mw [3][3];
  int mk [3][3];
  int pipe [3];
  int expOut = 0;

  function automatic int roundSum(input longint s);
    longint v;
    v = (s + 64'sd16) >>> 5;           // R7: add 2^-5, keep 4 fraction bits
    return int'(v & 64'hFFFF);         // R8: wrap to 16 bits
  endfunction

  always @(posedge clk) begin
    int px [3];
    int kc [3];
    longint s;
    px[0] = int'($signed(pixA)); px[1] = int'($signed(pixB)); px[2] = int'($signed(pixC));
    kc[0] = int'($signed(coefA)); kc[1] = int'($signed(coefB)); kc[2] = int'($signed(coefC));
    if (rst) begin
      for (int r = 0; r < 3; r++) for (int t = 0; t < 3; t++) begin mw[r][t] = 0; mk[r][t] = 0; end
      for (int i = 0; i < 3; i++) pipe[i] = 0;
      expOut = 0;
    end else begin
      s = longint'($signed(casIn)) * 32;
      for (int r = 0; r < 3; r++) for (int t = 0; t < 3; t++) s += longint'(mw[r][t]) * mk[r][t];
      expOut  = pipe[2];
      pipe[2] = pipe[1];
      pipe[1] = pipe[0];
      pipe[0] = roundSum(s);
      for (int r = 0; r < 3; r++) begin
        mw[r][0] = mw[r][1];
        mw[r][1] = mw[r][2];
        mw[r][2] = px[r];
        if (coefSel != 2'd0) mk[r][coefSel-1] = kc[r];
      end
    end
  end

  always @(negedge clk) begin
    if (checkOn && !done) begin
      total++;
      if (casOut !== 16'(expOut)) begin
        fails++;
        $display("FAIL %s: casOut=%h expected=%h", curReq, casOut, 16'(expOut));
      end
    end
  end

  task automatic drive(input int a, input int b, input int c, input int ka, input int kb,
                       input int kc, input int sel, input int cas);
    @(negedge clk);
    pixA = 12'(a); pixB = 12'(b); pixC = 12'(c);
    coefA = 10'(ka); coefB = 10'(kb); coefC = 10'(kc);
    coefSel = 2'(sel); casIn = 16'(cas);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    rst = 1'b1;
    pixA = '0; pixB = '0; pixC = '0; coefA = '0; coefB = '0; coefC = '0;
    coefSel = '0; casIn = '0;
    @(negedge clk);
    checkOn = 1'b1;                     // R9: output zero during and after reset
    repeat (2) @(negedge clk);
    rst = 1'b0;

    // R3: cascade only, coefficients all zero -> casOut equals casIn 3 edges on
    curReq = "R3";
    drive(0, 0, 0, 0, 0, 0, 0, 16'h1234);
    drive(0, 0, 0, 0, 0, 0, 0, 16'h8001);
    drive(0, 0, 0, 0, 0, 0, 0, 16'h7FFF);
    drive(0, 0, 0, 0, 0, 0, 0, -5);
    idle(5);

    // R5: load three sets with distinct values per row and position
    curReq = "R5";
    drive(0, 0, 0, 16, -100, 37, 1, 0);
    drive(0, 0, 0, -200, 64, -3, 2, 0);
    drive(0, 0, 0, 255, -512, 511, 3, 0);

    // R6: hold code with garbage on the coefficient ports
    curReq = "R6";
    drive(0, 0, 0, 99, 98, 97, 0, 0);
    drive(0, 0, 0, -99, -98, -97, 0, 0);

    // R4 / R1: impulse on each row, tap order visible at n+4..n+6
    curReq = "R4";
    drive(64, 0, 0, 1, 1, 1, 0, 0);
    idle(8);
    drive(0, 64, 0, 5, 5, 5, 0, 0);
    idle(8);
    curReq = "R1";
    drive(0, 0, 64, 0, 0, 0, 0, 0);
    idle(8);

    // R7: rounding boundary with 2^-5 products
    curReq = "R7";
    drive(0, 0, 0, 0, 0, 0, 1, 0);
    drive(0, 0, 0, 0, 0, 0, 2, 0);
    drive(0, 0, 0, 16, 0, 0, 3, 0);
    drive(1, 0, 0, 16, 0, 0, 3, 0); idle(7);
    drive(1, 0, 0, 15, 0, 0, 3, 0); idle(7);
    drive(1, 0, 0, -16, 0, 0, 3, 0); idle(7);
    drive(1, 0, 0, -17, 0, 0, 3, 0); idle(7);
    drive(0, 0, 0, 0, 0, 0, 0, 3); idle(6);

    // R8: full-scale negative pixels times -1.0 overflow and wrap
    curReq = "R8";
    for (int s = 1; s <= 3; s++) drive(0, 0, 0, -512, -512, -512, s, 0);
    for (int i = 0; i < 4; i++) drive(-2048, -2048, -2048, 0, 0, 0, 0, 16'h7FF0);
    idle(8);

    // R2 / R10: random columns, loads, holds and cascade values
    curReq = "R2";
    for (int i = 0; i < 400; i++)
      drive($urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
            (($urandom % 4) == 0) ? $urandom % 4 : 0, $urandom);
    curReq = "R10";
    for (int i = 0; i < 100; i++)
      drive($urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom % 4, $urandom);

    // R9: reset in mid-stream clears window, pipeline and coefficients
    curReq = "R9";
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 6; i++) drive(100, -100, 50, 0, 0, 0, 0, 0);
    idle(6);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      total++;
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule